// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen and Staged Host View

This block keeps calendar time in packed BCD (century, year, month, date, day of week, hours, minutes, seconds) in 24-hour form. It advances once for every pulse on a one-second enable input. Month lengths and leap years are handled in hardware. The time exists twice. A counting set advances on every second. A host-visible set is what the byte-wide register port returns. The port decodes the top eight byte addresses of a 13-bit address space.

The host can freeze the visible set so that it reads a coherent snapshot while the counter keeps running. It can also stage a new time in the visible set and commit it to the counter in a single step. Other controls are a stop bit that halts counting, and a test output that toggles on each pulse of a 1024 Hz enable. That gives a 512 Hz square wave when enabled. A neighbouring alarm/watchdog block supplies a single permit line, which is true when that block's own conditions for frequency test mode hold.

Top module: `rtc_calendar`

## Requirements
- R1: On each one-second enable while running, seconds advance by one in packed BCD (09 becomes 10, with the low nibble wrapping 9 to 0), and fields read back zero-extended.
- R2: The date rolls to 01 of the next month after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 (year 00 included) and 28 otherwise. All other months have 31 days.
- R3: The register offsets in the top eight addresses are: 0 control (bit 7 stage bit, bit 6 freeze bit, bits 5:0 century), 1 seconds (bit 7 stop bit), 2 minutes, 3 hours, 4 day of week (bit 6 test enable, bits 2:0 day), 5 date, 6 month, 7 year.
- R4: While the freeze bit is 1, the visible registers do not change on seconds ticks. The counter keeps advancing.
- R5: While the stage bit is 1, ticks do not change the visible registers, and host writes land only there. Writing the control register with bit 7 = 0 while staging loads the visible time into the counter, taking the century from bits 5:0 of that write.
- R6: After the freeze bit is cleared, the next running tick shows the counter's current count, including all seconds that passed while frozen.
- R7: After reset the stop bit reads 1, the test enable reads 0, and the time reads 00:00:00, day 01, date 01, month 01, year 00, century 00. While the stop bit is 1, ticks do not change the count.
- R8: The test output toggles on each 1024 Hz pulse while the test enable is 1, the stop bit is 0 and the permit input is 1. Otherwise it is 0 on the following cycle.
- R9: Writes whose address is outside the top eight locations have no effect. Reads from such addresses return 00h.
- R10: A seconds carry ripples through minutes (59), hours (23), date and day of week (07 wraps to 01), month (12), year (99) and century. Century 39 wraps to 00.
- R11: A host write to a time field while the stage bit is 0 changes only the visible copy. The next running tick replaces it with the counter's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_1024 | input | 1 | One-cycle pulse at 1024 Hz |
| ft_gate | input | 1 | Permit for the frequency-test output from the alarm/watchdog logic |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W (13) | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr`, combinational |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The bench builds the block with its defaults: a 13-bit address and century limit 39. It drives both tick enables directly instead of from a real prescaler, so every calendar boundary can be reached within a few cycles of staging a time. These include the year and century wrap, leap and non-leap February including year 00, and 30-day months. A per-cycle behavioural model checks the freeze and stage interactions against the counter as it runs on underneath.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [5:0] cen;
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_SEC  = 3'd1,
        REG_MIN  = 3'd2,
        REG_HR   = 3'd3,
        REG_DOW  = 3'd4,
        REG_DATE = 3'd5,
        REG_MON  = 3'd6,
        REG_YR   = 3'd7
    } rtc_reg_e;

    localparam rtc_time_t TIME_RESET = '{
        cen: 6'h00, yr: 8'h00, mon: 5'h01, date: 6'h01,
        dow: 3'h1, hr: 6'h00, mn: 7'h00, sec: 7'h00
    };

    // BCD year divisible by 4: 10*tens mod 4 depends only on tens parity.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] s;
        s = {yr[4], 1'b0} + yr[1:0];
        return (s == 2'd0);
    endfunction

    function automatic logic [5:0] month_len(input logic [4:0] mon,
                                             input logic [7:0] yr);
        case (mon)
            5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
    parameter int         W  = 7,
    parameter logic [W-1:0] LO = '0
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] top_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    localparam int TW = W - 4;

    logic [3:0]    ones;
    logic [TW-1:0] tens;
    logic [W-1:0]  stepped;
    logic          at_top;

    assign ones   = val_i[3:0];
    assign tens   = val_i[W-1:4];
    assign at_top = (val_i >= top_i);

    always_comb begin
        if (ones >= 4'd9) stepped = {tens + 1'b1, 4'd0};
        else              stepped = {tens, ones + 4'd1};
    end

    assign val_o   = !inc_i ? val_i : (at_top ? LO : stepped);
    assign carry_o = inc_i && at_top;
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
#(
    parameter logic [5:0] CEN_TOP = 6'h39
) (
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);
    logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;
    logic [5:0] dlen;

    assign dlen = month_len(cur_i.mon, cur_i.yr);

    rtc_bcd_field #(.W(7), .LO(7'h00)) u_sec (
        .val_i(cur_i.sec), .top_i(7'h59), .inc_i(1'b1),
        .val_o(nxt_o.sec), .carry_o(c_sec));
    rtc_bcd_field #(.W(7), .LO(7'h00)) u_min (
        .val_i(cur_i.mn), .top_i(7'h59), .inc_i(c_sec),
        .val_o(nxt_o.mn), .carry_o(c_min));
    rtc_bcd_field #(.W(6), .LO(6'h00)) u_hr (
        .val_i(cur_i.hr), .top_i(6'h23), .inc_i(c_min),
        .val_o(nxt_o.hr), .carry_o(c_hr));
    rtc_bcd_field #(.W(6), .LO(6'h01)) u_date (
        .val_i(cur_i.date), .top_i(dlen), .inc_i(c_hr),
        .val_o(nxt_o.date), .carry_o(c_date));
    rtc_bcd_field #(.W(5), .LO(5'h01)) u_mon (
        .val_i(cur_i.mon), .top_i(5'h12), .inc_i(c_date),
        .val_o(nxt_o.mon), .carry_o(c_mon));
    rtc_bcd_field #(.W(8), .LO(8'h00)) u_yr (
        .val_i(cur_i.yr), .top_i(8'h99), .inc_i(c_mon),
        .val_o(nxt_o.yr), .carry_o(c_yr));

    always_comb begin
        if (!c_hr)                    nxt_o.dow = cur_i.dow;
        else if (cur_i.dow >= 3'd7)   nxt_o.dow = 3'd1;
        else                          nxt_o.dow = cur_i.dow + 3'd1;
    end

    always_comb begin
        if (!c_yr)                    nxt_o.cen = cur_i.cen;
        else if (cur_i.cen >= CEN_TOP) nxt_o.cen = 6'h00;
        else if (cur_i.cen[3:0] >= 4'd9)
            nxt_o.cen = {cur_i.cen[5:4] + 2'd1, 4'd0};
        else
            nxt_o.cen = {cur_i.cen[5:4], cur_i.cen[3:0] + 4'd1};
    end
endmodule

// File: rtl/rtc_freq_test.sv
module rtc_freq_test (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic tick_i,
    output logic wave_o
);
    always_ff @(posedge clk) begin
        if (rst || !en_i)  wave_o <= 1'b0;
        else if (tick_i)   wave_o <= ~wave_o;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [5:0] CEN_TOP = 6'h39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              tick_1024,
    input  logic              ft_gate,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ft_out
);
    localparam int OFS_W = 3;

    rtc_time_t cnt_q, vis_q, cnt_nxt, load_val;
    logic      wbit_q, rbit_q, osc_stop_q, ft_bit_q;
    logic      page_hit, wr_hit, run, commit, ft_en;
    rtc_reg_e  sel;

    assign page_hit = &addr[ADDR_W-1:OFS_W];
    assign wr_hit   = wr_en && page_hit;
    assign sel      = rtc_reg_e'(addr[OFS_W-1:0]);
    assign run      = tick_1hz && !osc_stop_q;
    assign commit   = wr_hit && (sel == REG_CTRL) && wbit_q && !wdata[7];

    always_comb begin
        load_val     = vis_q;
        load_val.cen = wdata[5:0];
    end

    rtc_advance #(.CEN_TOP(CEN_TOP)) u_adv (
        .cur_i(cnt_q),
        .nxt_o(cnt_nxt)
    );

    // Counting set
    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= TIME_RESET;
        else if (commit) cnt_q <= load_val;
        else if (run)    cnt_q <= cnt_nxt;
    end

    // Visible set and control bits
    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q      <= TIME_RESET;
            wbit_q     <= 1'b0;
            rbit_q     <= 1'b0;
            osc_stop_q <= 1'b1;
            ft_bit_q   <= 1'b0;
        end else begin
            if (run && !rbit_q && !wbit_q) vis_q <= cnt_nxt;
            if (wr_hit) begin
                case (sel)
                    REG_CTRL: begin
                        wbit_q    <= wdata[7];
                        rbit_q    <= wdata[6];
                        vis_q.cen <= wdata[5:0];
                    end
                    REG_SEC: begin
                        osc_stop_q <= wdata[7];
                        vis_q.sec  <= wdata[6:0];
                    end
                    REG_MIN:  vis_q.mn   <= wdata[6:0];
                    REG_HR:   vis_q.hr   <= wdata[5:0];
                    REG_DOW: begin
                        ft_bit_q  <= wdata[6];
                        vis_q.dow <= wdata[2:0];
                    end
                    REG_DATE: vis_q.date <= wdata[5:0];
                    REG_MON:  vis_q.mon  <= wdata[4:0];
                    REG_YR:   vis_q.yr   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (page_hit) begin
            case (sel)
                REG_CTRL: rdata = {wbit_q, rbit_q, vis_q.cen};
                REG_SEC:  rdata = {osc_stop_q, vis_q.sec};
                REG_MIN:  rdata = {1'b0, vis_q.mn};
                REG_HR:   rdata = {2'b00, vis_q.hr};
                REG_DOW:  rdata = {1'b0, ft_bit_q, 3'b000, vis_q.dow};
                REG_DATE: rdata = {2'b00, vis_q.date};
                REG_MON:  rdata = {3'b000, vis_q.mon};
                REG_YR:   rdata = vis_q.yr;
                default:  rdata = 8'h00;
            endcase
        end
    end

    assign ft_en = ft_bit_q && !osc_stop_q && ft_gate;

    rtc_freq_test u_ft (
        .clk   (clk),
        .rst   (rst),
        .en_i  (ft_en),
        .tick_i(tick_1024),
        .wave_o(ft_out)
    );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      run,
    input logic      commit,
    input logic      wr_hit,
    input logic      osc_stop_q,
    input logic      ft_bit_q,
    input logic      rbit_q,
    input logic      wbit_q,
    input logic      ft_en,
    input logic      ft_out,
    input rtc_time_t cnt_q,
    input rtc_time_t vis_q
);
    AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (osc_stop_q && !ft_bit_q)); // R7

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (osc_stop_q && !commit) |=> $stable(cnt_q)); // R7

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rbit_q && !wr_hit) |=> $stable(vis_q)); // R4

    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wbit_q && !wr_hit) |=> $stable(vis_q)); // R5

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt_q.sec == $past(vis_q.sec) &&
                    cnt_q.hr  == $past(vis_q.hr)  &&
                    cnt_q.yr  == $past(vis_q.yr))); // R5

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !commit && cnt_q.sec == 7'h59) |=> (cnt_q.sec == 7'h00)); // R10

    AST_FT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ft_en |=> !ft_out); // R8
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .commit    (commit),
    .wr_hit    (wr_hit),
    .osc_stop_q(osc_stop_q),
    .ft_bit_q  (ft_bit_q),
    .rbit_q    (rbit_q),
    .wbit_q    (wbit_q),
    .ft_en     (ft_en),
    .ft_out    (ft_out),
    .cnt_q     (cnt_q),
    .vis_q     (vis_q)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0, tick_1024 = 1'b0, ft_gate = 1'b0, wr_en = 1'b0;
    logic [12:0] addr = 13'h0;
    logic [7:0]  wdata = 8'h0;
    logic [7:0]  rdata;
    logic        ft_out;

    int vectors = 0, fails = 0;
    string phase = "R7";
    bit done = 0;

    localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
        A_HR = 13'h1FFB, A_DOW = 13'h1FFC, A_DATE = 13'h1FFD, A_MON = 13'h1FFE,
        A_YR = 13'h1FFF;

    rtc_calendar uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_1024(tick_1024),
        .ft_gate(ft_gate), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ft_out(ft_out));

    always #10 clk = ~clk;

    // Reference model: index 0 century, 1 sec, 2 min, 3 hour, 4 dow, 5 date, 6 month, 7 year
    int t[8], v[8];
    bit m_wb, m_rb, m_osc, m_ft, m_wave;

    function automatic int bin(input int x); return (x >> 4) * 10 + (x & 15); endfunction
    function automatic int bcd(input int n); return (n / 10) * 16 + (n % 10); endfunction
    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        t = '{0, 0, 0, 0, 1, 1, 1, 0};
        v = t;
        m_wb = 0; m_rb = 0; m_osc = 1; m_ft = 0; m_wave = 0;
    endtask

    task automatic adv(inout int a[8]);
        a[1]++;
        if (a[1] == 60) begin
            a[1] = 0; a[2]++;
            if (a[2] == 60) begin
                a[2] = 0; a[3]++;
                if (a[3] == 24) begin
                    a[3] = 0;
                    a[4] = (a[4] == 7) ? 1 : a[4] + 1;
                    a[5]++;
                    if (a[5] > dim(a[6], a[7])) begin
                        a[5] = 1; a[6]++;
                        if (a[6] == 13) begin
                            a[6] = 1; a[7]++;
                            if (a[7] == 100) begin
                                a[7] = 0;
                                a[0] = (a[0] == 39) ? 0 : a[0] + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    function automatic int m_read(input logic [12:0] a);
        if (a[12:3] != 10'h3FF) return 0;
        case (a[2:0])
            3'd0: return (int'(m_wb) << 7) | (int'(m_rb) << 6) | bcd(v[0]);
            3'd1: return (int'(m_osc) << 7) | bcd(v[1]);
            3'd4: return (int'(m_ft) << 6) | v[4];
            default: return bcd(v[a[2:0]]);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) m_reset();
        else begin
            int n[8];
            bit run, wh, cm;
            int d, off;
            run = tick_1hz && !m_osc;
            n = t;
            if (run) adv(n);
            if (m_ft && !m_osc && ft_gate) begin
                if (tick_1024) m_wave = !m_wave;
            end else m_wave = 0;
            wh  = wr_en && (addr[12:3] == 10'h3FF);
            off = addr[2:0];
            d   = wdata;
            cm  = wh && off == 0 && m_wb && !wdata[7];
            if (cm) begin t = v; t[0] = bin(d & 8'h3F); end
            else if (run) t = n;
            if (run && !m_rb && !m_wb) v = n;
            if (wh) begin
                case (off)
                    0: begin m_wb = d[7]; m_rb = d[6]; v[0] = bin(d & 8'h3F); end
                    1: begin m_osc = d[7]; v[1] = bin(d & 8'h7F); end
                    2: v[2] = bin(d & 8'h7F);
                    3: v[3] = bin(d & 8'h3F);
                    4: begin m_ft = d[6]; v[4] = d & 7; end
                    5: v[5] = bin(d & 8'h3F);
                    6: v[6] = bin(d & 8'h1F);
                    default: v[7] = bin(d);
                endcase
            end
        end
        #5;
        check(int'(rdata) == m_read(addr), {phase, " per-cycle rdata"}, rdata, m_read(addr));
        check(ft_out == m_wave, {phase, " per-cycle ft_out"}, ft_out, m_wave);
    end

    task automatic hwrite(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1;
            @(negedge clk); tick_1hz = 0;
        end
    endtask

    task automatic rd(input logic [12:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; #2;
        check(rdata == exp, tag, rdata, exp);
    endtask

    task automatic fast_pulse();
        @(negedge clk); tick_1024 = 1;
        @(negedge clk); tick_1024 = 0;
    endtask

    task automatic set_time(input logic [7:0] c, y, mo, dt, dw, h, mi, s);
        hwrite(A_CTRL, 8'h80 | c);
        hwrite(A_YR, y); hwrite(A_MON, mo); hwrite(A_DATE, dt); hwrite(A_DOW, dw);
        hwrite(A_HR, h); hwrite(A_MIN, mi); hwrite(A_SEC, s);
        hwrite(A_CTRL, c);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R7";
        rd(A_CTRL, 8'h00, "R7 ctrl after reset");
        rd(A_SEC, 8'h80, "R7 stopped after reset");
        rd(A_DOW, 8'h01, "R7 day after reset");
        rd(A_DATE, 8'h01, "R7 date after reset");
        rd(A_MON, 8'h01, "R7 month after reset");
        ticks(3);
        rd(A_SEC, 8'h80, "R7 stopped ignores ticks");

        phase = "R1";
        hwrite(A_SEC, 8'h00);
        ticks(10);
        rd(A_SEC, 8'h10, "R1 BCD 09 to 10");
        rd(A_MIN, 8'h00, "R1 minutes untouched");

        phase = "R10";
        set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        ticks(1);
        rd(A_SEC, 8'h59, "R10 second 59");
        ticks(1);
        rd(A_CTRL, 8'h00, "R10 century 39 wraps");
        rd(A_YR, 8'h00, "R10 year wraps");
        rd(A_MON, 8'h01, "R10 month wraps");
        rd(A_DATE, 8'h01, "R10 date wraps");
        rd(A_DOW, 8'h01, "R10 day of week wraps");
        rd(A_HR, 8'h00, "R10 hours wrap");

        phase = "R2";
        set_time(8'h00, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(1);
        rd(A_DATE, 8'h29, "R2 leap Feb 29");
        set_time(8'h00, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(1);
        rd(A_MON, 8'h03, "R2 common Feb ends");
        rd(A_DATE, 8'h01, "R2 common Feb to Mar 01");
        set_time(8'h00, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(1);
        rd(A_DATE, 8'h29, "R2 year 00 leap");
        set_time(8'h00, 8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(1);
        rd(A_MON, 8'h03, "R2 Feb 29 to March");
        set_time(8'h00, 8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        ticks(1);

        phase = "R3";
        rd(A_CTRL, 8'h00, "R3 offset 0");
        rd(A_SEC, 8'h00, "R3 offset 1");
        rd(A_MIN, 8'h00, "R3 offset 2");
        rd(A_HR, 8'h00, "R3 offset 3");
        rd(A_DOW, 8'h06, "R3 offset 4");
        rd(A_DATE, 8'h01, "R3 offset 5 (R2 30-day month)");
        rd(A_MON, 8'h05, "R3 offset 6");
        rd(A_YR, 8'h23, "R3 offset 7");

        phase = "R4";
        hwrite(A_CTRL, 8'h40);
        rd(A_CTRL, 8'h40, "R4 freeze bit set");
        ticks(3);
        rd(A_SEC, 8'h00, "R4 frozen seconds");
        phase = "R6";
        hwrite(A_CTRL, 8'h00);
        rd(A_SEC, 8'h00, "R6 no refresh before tick");
        ticks(1);
        rd(A_SEC, 8'h04, "R6 resumes with counter value");

        phase = "R5";
        hwrite(A_CTRL, 8'h80);
        ticks(2);
        rd(A_SEC, 8'h04, "R5 staged view holds");
        hwrite(A_SEC, 8'h30);
        rd(A_SEC, 8'h30, "R5 staged write visible");
        ticks(2);
        rd(A_SEC, 8'h30, "R5 staged value kept");
        hwrite(A_CTRL, 8'h00);
        ticks(1);
        rd(A_SEC, 8'h31, "R5 commit loads counter");

        phase = "R11";
        hwrite(A_MIN, 8'h45);
        rd(A_MIN, 8'h45, "R11 direct write visible");
        ticks(1);
        rd(A_MIN, 8'h00, "R11 tick restores counter minutes");
        rd(A_SEC, 8'h32, "R11 seconds from counter");

        phase = "R8";
        hwrite(A_DOW, 8'h46);
        rd(A_DOW, 8'h46, "R8 test enable readback");
        @(negedge clk); ft_gate = 1;
        fast_pulse(); #2;
        check(ft_out == 1'b1, "R8 first toggle", ft_out, 1);
        fast_pulse(); #2;
        check(ft_out == 1'b0, "R8 second toggle", ft_out, 0);
        fast_pulse();
        @(negedge clk); ft_gate = 0;
        @(negedge clk); #2;
        check(ft_out == 1'b0, "R8 permit low forces 0", ft_out, 0);
        @(negedge clk); ft_gate = 1;

        phase = "R7";
        hwrite(A_SEC, 8'hB2);
        fast_pulse(); #2;
        check(ft_out == 1'b0, "R8 stopped oscillator blocks output", ft_out, 0);
        ticks(3);
        rd(A_SEC, 8'hB2, "R7 stop bit holds count");

        phase = "R9";
        hwrite(13'h0FF9, 8'h00);
        rd(A_SEC, 8'hB2, "R9 off-page write ignored");
        rd(13'h0FF9, 8'h00, "R9 off-page read zero");
        hwrite(13'h1FE8, 8'h80);
        rd(A_CTRL, 8'h00, "R9 lower page control alias ignored");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule